// File: doc/BRIEF.md
# Bidirectional latched bus transceiver

This block passes data between two parallel ports, A and B, through two independent transparent latches: one latch carries data from A toward B, and the other carries data from B toward A. Each direction has three active-low controls of its own. A chip select gates everything in that direction. A latch enable opens the latch while it is low and closes it on its rising edge. An output enable, together with the chip select, decides whether the far port is driven.

Each port is a split triple: data in, data out and a drive indication. An external tri-state wrapper can then build a real bus pin from them. The data shown on a port always comes from the latch of that direction and never straight from the opposite port's input. An optional active-low asynchronous reset clears both latches.

Top module: `duplex_hold_xcvr`

## Requirements
- R1: The A-to-B and B-to-A latches are independent: loading one leaves the value stored in the other unchanged.
- R2: While `ab_cs_n` is 1, the A-to-B latch keeps its value and `b_oe` is 0, whatever `ab_le_n`, `ab_oe_n` and `a_in` do.
- R3: With `ab_cs_n`=0 and `ab_le_n`=0 the A-to-B latch is transparent, so with `ab_oe_n`=0, `b_out` equals the present `a_in`.
- R4: A rising edge of `ab_le_n` while `ab_cs_n`=0 captures the current `a_in`; later changes of `a_in` do not reach `b_out` until the latch reopens.
- R5: `b_oe` is 1 exactly when `ab_cs_n`=0 and `ab_oe_n`=0; with the default `IDLE_ZERO`=1, `b_out` reads all zeros whenever `b_oe` is 0.
- R6: The value driven on `b_out` is the stored latch content, not the live `a_in`.
- R7: The B-to-A direction behaves in the same way with `ba_cs_n`, `ba_le_n` and `ba_oe_n`, and drives `a_out`/`a_oe` from its own latch.
- R8: The latch enable and the output enable act independently: data may be loaded while the output is disabled and appears once the output is enabled.
- R9: While `rst_n` is 0 (with `USE_RESET`=1), both latches read zero and ignore their inputs, whatever the other controls do.
- R10: With both directions enabled at once, each port shows its own direction's latch, and there is no arbitration between the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous clear of both latches, active low |
| ab_cs_n | input | 1 | A-to-B chip select, active low |
| ab_le_n | input | 1 | A-to-B latch enable, low = transparent |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_cs_n | input | 1 | B-to-A chip select, active low |
| ba_le_n | input | 1 | B-to-A latch enable, low = transparent |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| a_in | input | W | Value seen on port A |
| a_out | output | W | Value for port A from the B-to-A latch |
| a_oe | output | 1 | Port A is actively driven |
| b_in | input | W | Value seen on port B |
| b_out | output | W | Value for port B from the A-to-B latch |
| b_oe | output | 1 | Port B is actively driven |

## Verification
Data patterns are presented while a latch is open and again after it has closed. A change that shows up only in the open phase tells transparency apart from capture, and a closed-latch change tells stored data apart from the live input. The controls are swept over every chip-select and output-enable pair with the data held still, which isolates the drive indication from the latch contents. Loads in one direction with the other held, runs with both directions enabled, and a reset in the middle of a run tell independent storage apart from shared or stale state.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   typedef struct packed {
      logic cs_n;
      logic le_n;
      logic oe_n;
   } dir_ctl_t;

   localparam int NUM_DIRS = 2;
   localparam int DIR_AB   = 0;
   localparam int DIR_BA   = 1;

   function automatic logic ctl_loads(input dir_ctl_t c);
      return !c.cs_n && !c.le_n;
   endfunction

   function automatic logic ctl_drives(input dir_ctl_t c);
      return !c.cs_n && !c.oe_n;
   endfunction

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store
   import xcvr_pkg::*;
#(
   parameter int W         = 8,
   parameter bit USE_RESET = 1'b1
) (
   input  logic         rst_n,
   input  dir_ctl_t     ctl,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);
   logic load;
   assign load = ctl_loads(ctl);

   generate
      if (USE_RESET) begin : g_clr
         always_latch begin
            if (!rst_n)
               q = '0;
            else if (load)
               q = din;
         end
      end else begin : g_noclr
         logic unused_rst;
         assign unused_rst = rst_n;
         always_latch begin
            if (load)
               q = din;
         end
      end
   endgenerate
endmodule

// File: rtl/xcvr_gate.sv
module xcvr_gate
   import xcvr_pkg::*;
#(
   parameter int W         = 8,
   parameter bit IDLE_ZERO = 1'b1
) (
   input  dir_ctl_t     ctl,
   input  logic [W-1:0] q,
   output logic [W-1:0] dout,
   output logic         oe
);
   assign oe = ctl_drives(ctl);

   generate
      if (IDLE_ZERO) begin : g_zero
         assign dout = oe ? q : '0;
      end else begin : g_pass
         assign dout = q;
      end
   endgenerate
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
   import xcvr_pkg::*;
#(
   parameter int W         = 8,
   parameter bit USE_RESET = 1'b1,
   parameter bit IDLE_ZERO = 1'b1
) (
   input  logic         rst_n,
   input  dir_ctl_t     ctl,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic         oe
);
   logic [W-1:0] held;

   xcvr_store #(.W(W), .USE_RESET(USE_RESET)) u_store (
      .rst_n (rst_n),
      .ctl   (ctl),
      .din   (din),
      .q     (held)
   );

   xcvr_gate #(.W(W), .IDLE_ZERO(IDLE_ZERO)) u_gate (
      .ctl  (ctl),
      .q    (held),
      .dout (dout),
      .oe   (oe)
   );
endmodule

// File: rtl/duplex_hold_xcvr.sv
module duplex_hold_xcvr
   import xcvr_pkg::*;
#(
   parameter int W         = 8,
   parameter bit USE_RESET = 1'b1,
   parameter bit IDLE_ZERO = 1'b1
) (
   input  logic         rst_n,
   input  logic         ab_cs_n,
   input  logic         ab_le_n,
   input  logic         ab_oe_n,
   input  logic         ba_cs_n,
   input  logic         ba_le_n,
   input  logic         ba_oe_n,
   input  logic [W-1:0] a_in,
   output logic [W-1:0] a_out,
   output logic         a_oe,
   input  logic [W-1:0] b_in,
   output logic [W-1:0] b_out,
   output logic         b_oe
);
   generate
      if (W < 1) begin : g_bad_width
         $error("duplex_hold_xcvr: W must be at least 1");
      end
   endgenerate

   dir_ctl_t     ctl  [NUM_DIRS];
   logic [W-1:0] src  [NUM_DIRS];
   logic [W-1:0] dst  [NUM_DIRS];
   logic         drv  [NUM_DIRS];

   assign ctl[DIR_AB] = '{cs_n: ab_cs_n, le_n: ab_le_n, oe_n: ab_oe_n};
   assign ctl[DIR_BA] = '{cs_n: ba_cs_n, le_n: ba_le_n, oe_n: ba_oe_n};
   assign src[DIR_AB] = a_in;
   assign src[DIR_BA] = b_in;

   generate
      for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
         xcvr_lane #(.W(W), .USE_RESET(USE_RESET), .IDLE_ZERO(IDLE_ZERO)) u_lane (
            .rst_n (rst_n),
            .ctl   (ctl[d]),
            .din   (src[d]),
            .dout  (dst[d]),
            .oe    (drv[d])
         );
      end
   endgenerate

   assign b_out = dst[DIR_AB];
   assign b_oe  = drv[DIR_AB];
   assign a_out = dst[DIR_BA];
   assign a_oe  = drv[DIR_BA];
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
   parameter int W         = 8,
   parameter bit USE_RESET = 1'b1,
   parameter bit IDLE_ZERO = 1'b1
) (
   input logic         rst_n,
   input logic         ab_cs_n,
   input logic         ab_le_n,
   input logic         ab_oe_n,
   input logic         ba_cs_n,
   input logic         ba_le_n,
   input logic         ba_oe_n,
   input logic [W-1:0] a_in,
   input logic [W-1:0] a_out,
   input logic         a_oe,
   input logic [W-1:0] b_in,
   input logic [W-1:0] b_out,
   input logic         b_oe
);
   always_comb begin
      // R2: deselected direction never drives its far port
      if (ab_cs_n) begin
         a_r2_no_drive_deselected: assert (!b_oe)
            else $error("R2 b_oe high with ab_cs_n high");
      end
      // R5: driven when both enables are low
      if (!ab_cs_n && !ab_oe_n) begin
         a_r5_drive_when_enabled: assert (b_oe)
            else $error("R5 b_oe low with both enables low");
      end
      if (ab_oe_n) begin
         a_r5_no_drive_oe_high: assert (!b_oe)
            else $error("R5 b_oe high with ab_oe_n high");
      end
      // R5: idle port reads zero
      if (IDLE_ZERO && !b_oe) begin
         a_r5_idle_zero: assert (b_out == '0)
            else $error("R5 b_out nonzero while idle");
      end
      // R3: open latch with output enabled passes A through
      if (rst_n && !ab_cs_n && !ab_le_n && !ab_oe_n) begin
         a_r3_transparent: assert (b_out == a_in)
            else $error("R3 b_out differs from a_in while open");
      end
      // R7: same rules for B-to-A
      if (ba_cs_n) begin
         a_r7_no_drive_deselected: assert (!a_oe)
            else $error("R7 a_oe high with ba_cs_n high");
      end
      if (rst_n && !ba_cs_n && !ba_le_n && !ba_oe_n) begin
         a_r7_transparent: assert (a_out == b_in)
            else $error("R7 a_out differs from b_in while open");
      end
      // R9: reset clears both stores
      if (USE_RESET && !rst_n && b_oe) begin
         a_r9_clear_ab: assert (b_out == '0)
            else $error("R9 b_out nonzero in reset");
      end
      if (USE_RESET && !rst_n && a_oe) begin
         a_r9_clear_ba: assert (a_out == '0)
            else $error("R9 a_out nonzero in reset");
      end
   end
endmodule

bind duplex_hold_xcvr xcvr_chk #(.W(W), .USE_RESET(USE_RESET), .IDLE_ZERO(IDLE_ZERO)) u_chk (
   .rst_n   (rst_n),
   .ab_cs_n (ab_cs_n),
   .ab_le_n (ab_le_n),
   .ab_oe_n (ab_oe_n),
   .ba_cs_n (ba_cs_n),
   .ba_le_n (ba_le_n),
   .ba_oe_n (ba_oe_n),
   .a_in    (a_in),
   .a_out   (a_out),
   .a_oe    (a_oe),
   .b_in    (b_in),
   .b_out   (b_out),
   .b_oe    (b_oe)
);

// File: tb/sim_duplex_hold_xcvr.sv
`timescale 1ns/1ps
module sim_duplex_hold_xcvr;
   localparam int W = 8;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic         rst_n;
   logic         ab_cs_n, ab_le_n, ab_oe_n;
   logic         ba_cs_n, ba_le_n, ba_oe_n;
   logic [W-1:0] a_in, b_in;
   logic [W-1:0] a_out, b_out;
   logic         a_oe, b_oe;

   duplex_hold_xcvr #(.W(W)) u0 (
      .rst_n(rst_n), .ab_cs_n(ab_cs_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
      .ba_cs_n(ba_cs_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
   );

   int tests = 0;
   int fails = 0;
   logic [W-1:0] ref_ab = '0;
   logic [W-1:0] ref_ba = '0;
   bit done = 0;

   task automatic cmp(input string tag, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("[TB] FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // Behavioural reference evaluated once per cycle, away from the clock edge
   task automatic step(input string tag);
      logic exp_boe, exp_aoe;
      @(negedge clk);
      if (!rst_n) begin
         ref_ab = '0;
         ref_ba = '0;
      end else begin
         if (!ab_cs_n && !ab_le_n) ref_ab = a_in;
         if (!ba_cs_n && !ba_le_n) ref_ba = b_in;
      end
      exp_boe = !ab_cs_n && !ab_oe_n;
      exp_aoe = !ba_cs_n && !ba_oe_n;
      cmp(tag, "b_oe",  int'(b_oe),  int'(exp_boe));
      cmp(tag, "b_out", int'(b_out), exp_boe ? int'(ref_ab) : 0);
      cmp(tag, "a_oe",  int'(a_oe),  int'(exp_aoe));
      cmp(tag, "a_out", int'(a_out), exp_aoe ? int'(ref_ba) : 0);
      @(posedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("[TB] FAIL watchdog expired actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 0;
      ab_cs_n = 0; ab_le_n = 1; ab_oe_n = 0;
      ba_cs_n = 0; ba_le_n = 1; ba_oe_n = 0;
      a_in = 8'hAA; b_in = 8'h55;
      @(posedge clk);
      step("R9");                         // reset: outputs driven, zero
      ab_le_n = 0; ba_le_n = 0; step("R9"); // open latches ignored in reset
      ab_le_n = 1; ba_le_n = 1; step("R9");
      rst_n = 1; step("R9");              // still zero after release

      // R3 transparency on A-to-B
      ab_le_n = 0; step("R3");
      a_in = 8'h12; step("R3");
      a_in = 8'hF0; step("R3");
      a_in = 8'h5A; step("R3");
      // R4 capture on rising latch enable, then A changes are ignored
      ab_le_n = 1; step("R4");
      a_in = 8'hC3; step("R4");
      a_in = 8'h3C; step("R4");

      // R2 deselected: hold and no drive regardless of other controls
      ab_cs_n = 1; step("R2");
      ab_le_n = 0; step("R2");
      a_in = 8'h99; step("R2");
      ab_oe_n = 1; step("R2");
      ab_le_n = 1; step("R2");
      ab_oe_n = 0; step("R2");
      ab_cs_n = 0; step("R2");            // shows the 5A captured earlier

      // R6/R8 load while output disabled, then show latched not live
      ab_oe_n = 1; step("R8");
      a_in = 8'h61; step("R8");
      ab_le_n = 0; step("R8");
      ab_le_n = 1; step("R8");
      a_in = 8'h07; step("R6");
      ab_oe_n = 0; step("R6");            // expect 61, a_in is 07

      // R7 B-to-A transparency and capture
      ba_le_n = 0; step("R7");
      b_in = 8'h81; step("R7");
      b_in = 8'h2E; step("R7");
      ba_le_n = 1; step("R7");
      b_in = 8'hD4; step("R7");
      ba_cs_n = 1; step("R7");
      ba_cs_n = 0; ba_oe_n = 1; step("R7");
      ba_oe_n = 0; step("R7");

      // R1 loading A-to-B leaves B-to-A store untouched
      ab_le_n = 0; a_in = 8'hE1; step("R1");
      a_in = 8'h1E; step("R1");
      ab_le_n = 1; step("R1");
      b_in = 8'h44; ba_le_n = 0; step("R1");
      ba_le_n = 1; step("R1");

      // R10 both directions driving at once from their own stores
      a_in = 8'hFF; b_in = 8'h00; step("R10");
      ab_le_n = 0; step("R10");
      ab_le_n = 1; ba_le_n = 0; step("R10");
      ba_le_n = 1; a_in = 8'h0F; b_in = 8'hF0; step("R10");

      // R5 every chip-select / output-enable pair, both directions
      for (int i = 0; i < 16; i++) begin
         {ab_cs_n, ab_oe_n, ba_cs_n, ba_oe_n} = 4'(i);
         step("R5");
      end

      // R2/R5 mixed sweep: alternate control-only and data-only changes
      for (int i = 0; i < 200; i++) begin
         if (i % 2 == 0) begin
            {ab_cs_n, ab_le_n, ab_oe_n, ba_cs_n, ba_le_n, ba_oe_n} = 6'($urandom);
            step("R2");
         end else begin
            a_in = 8'($urandom);
            b_in = 8'($urandom);
            step("R5");
         end
      end

      // R9 asynchronous clear in the middle of a run
      ab_cs_n = 0; ab_le_n = 0; ab_oe_n = 0;
      ba_cs_n = 0; ba_le_n = 0; ba_oe_n = 0;
      a_in = 8'hA5; b_in = 8'h5A; step("R9");
      ab_le_n = 1; ba_le_n = 1; step("R9");
      rst_n = 0; step("R9");
      rst_n = 1; step("R9");
      a_in = 8'h11; step("R9");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule